// File: doc/BRIEF.md
# Exception priority resolver and vector generator

The block collects pending exception requests from a processor core's surroundings and picks the one to service next. The sources are:

- a reset request, an NMI and a hard fault, which have fixed levels above everything else;
- memory-management, bus and usage faults;
- a supervisor-call strobe and a debug-monitor request;
- a software-pendable service request and a system-tick request;
- a parameterized set of peripheral interrupt lines.

Every source other than the three fixed ones has a 3-bit programmable priority and an enable bit. A disabled request stays pending but cannot win.

The winner's priority is compared with the priority of the exception the core is running now. The block then reports three registered results: the winning exception number, its byte offset in the vector table, and whether it may preempt. When the core accepts the winner, it pulses `take_i`, and that clears the latched request.

Top module: `exc_prio_resolver`

## Requirements
- R1: While reset is held and in the cycle after release with nothing pending, `pend_any_o`, `preempt_o`, `exc_num_o` and `vec_off_o` are all 0. Whenever no eligible request exists, `exc_num_o` and `vec_off_o` read 0.
- R2: Fixed order. Reset request (number 1) beats NMI (2), NMI beats hard fault (3), and hard fault beats every programmable source, whatever its level. These three need no enable.
- R3: Among programmable sources the lower 3-bit priority value wins. On equal values the lower exception number wins. Numbers are: memory fault 4, bus fault 5, usage fault 6, supervisor call 11, debug monitor 12, pendable service 14, system tick 15, and peripheral line k is 16+k.
- R4: A disabled programmable source keeps its pending state but is never selected. Enabling it later makes it selectable.
  - Register address 0 sets enables and address 1 clears them, where a 1 in the written data selects an enable.
  - Enable bits: 0 memory fault, 1 bus fault, 2 usage fault, 3 supervisor call, 4 debug monitor, 5 pendable service, 6 system tick, and 8+k for peripheral line k.
- R5: The debug monitor request (number 12) is never selected while its enable (bit 4) is clear.
- R6: `vec_off_o` equals `exc_num_o` times 4. For example NMI gives 0x08, supervisor call 0x2C and debug monitor 0x30.
- R7: `preempt_o` is 1 only when a winner exists and its level is strictly more urgent than the active level.
  - The active level is `act_prio_i`, read as a signed value, with -3, -2 and -1 for the fixed three and 0..7 for programmable levels. It is sampled only while `act_vld_i` is 1.
  - With `act_vld_i` low, any winner preempts. An equal level does not preempt.
- R8: The pendable service request is set by writing address 4 with bit 0 set. The system tick request is set either by writing address 4 with bit 1 set, or by `tick_zero_i` while the tick interrupt enable is 1.
  - Every write to address 4 loads the tick interrupt enable from bit 2. It resets to 0.
- R9: Peripheral lines are level requests. Each passes a two-flop synchronizer, so a change on `irq_i` shows on the outputs at the third rising edge after it.
- R10: A one-cycle pulse on a fault, supervisor-call, debug, reset-request, NMI or tick input is latched as pending. The result shows on the outputs at the second rising edge after the pulse starts.
- R11: A `take_i` pulse while `preempt_o` is 1 clears the latched pending request of the shown winner. `take_i` while `preempt_o` is 0 has no effect.
- R12: `exc_num_o` never shows a reserved number (7, 8, 9, 10 or 13) and never shows 0 while `pend_any_o` is 1.
- R13: Register writes take effect on the outputs at the second rising edge after `reg_we_i` is raised.
  - Address 2 holds system-source priorities at bits 3j..3j+2, in enable-bit order j.
  - Address 3 holds the priority of peripheral line k at bits 4k..4k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Reset exception request pulse |
| nmi_i | input | 1 | NMI request pulse |
| hard_fault_i | input | 1 | Hard fault request pulse |
| mem_fault_i | input | 1 | Memory management fault pulse |
| bus_fault_i | input | 1 | Bus fault pulse |
| usage_fault_i | input | 1 | Usage fault pulse |
| svc_i | input | 1 | Supervisor call strobe |
| dbg_mon_i | input | 1 | Debug monitor request pulse |
| tick_zero_i | input | 1 | System tick timer reached zero |
| irq_i | input | NUM_IRQ | Asynchronous peripheral interrupt levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| act_vld_i | input | 1 | An exception is active |
| act_prio_i | input | PRIO_W+1 | Signed level of the active exception |
| take_i | input | 1 | Core accepts the shown winner |
| pend_any_o | output | 1 | An eligible request exists |
| preempt_o | output | 1 | Winner may preempt the active level |
| exc_num_o | output | 8 | Winning exception number |
| vec_off_o | output | 10 | Vector table byte offset of the winner |

## Verification
Latched requests, register writes and `take_i` act on the pending or configuration flops at the first rising edge. The registered outputs then follow at the next edge, so checks for these stimuli sample at the falling edge after the second edge. Peripheral lines cross two synchronizer flops before that output register, so table vectors and latency checks sample on the third falling edge after `irq_i` changes. The first check is made one edge earlier to confirm nothing appears too soon. Changes on `act_vld_i` and `act_prio_i` reach `preempt_o` in a single edge and are checked one falling edge after they change.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;
  localparam int FIX_N    = 3;   // reset, nmi, hard fault
  localparam int SYS_N    = 7;   // programmable system sources
  localparam int LAT_N    = FIX_N + SYS_N;
  localparam int NUM_W    = 8;
  localparam int OFF_W    = NUM_W + 2;
  localparam int IRQ_BASE = 16;
  localparam int DBG_SYS  = 4;
  localparam int PSV_SYS  = 5;
  localparam int STK_SYS  = 6;

  typedef logic [NUM_W-1:0] exc_num_t;

  // source index -> exception number; indices ascend with number
  function automatic exc_num_t src_num(int idx);
    case (idx)
      0: return exc_num_t'(1);
      1: return exc_num_t'(2);
      2: return exc_num_t'(3);
      3: return exc_num_t'(4);
      4: return exc_num_t'(5);
      5: return exc_num_t'(6);
      6: return exc_num_t'(11);
      7: return exc_num_t'(12);
      8: return exc_num_t'(14);
      9: return exc_num_t'(15);
      default: return exc_num_t'(IRQ_BASE + idx - LAT_N);
    endcase
  endfunction

  function automatic logic is_reserved(exc_num_t n);
    return (n == '0) || ((n >= 8'd7) && (n <= 8'd10)) || (n == 8'd13);
  endfunction
endpackage

// File: rtl/exc_irq_sync.sv
module exc_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[0], async_i[g]};
    end
    assign sync_o[g] = ff_q[1];
  end
endmodule

// File: rtl/exc_cfg_regs.sv
module exc_cfg_regs
  import exc_prio_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [SYS_N-1:0]                 sys_en_o,
  output logic [NUM_IRQ-1:0]               irq_en_o,
  output logic [SYS_N-1:0][PRIO_W-1:0]     sys_prio_o,
  output logic [NUM_IRQ-1:0][PRIO_W-1:0]   irq_prio_o,
  output logic                             psv_set_o,
  output logic                             stk_sw_set_o,
  output logic                             tick_ie_o
);
  localparam int IRQ_EN_LSB = 8;
  localparam int IRQ_STRIDE = 4;
  localparam logic [ADDR_W-1:0] A_EN_SET  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN_CLR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SYS_PRI = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_IRQ_PRI = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(4);

  logic [SYS_N-1:0]               sys_en_q;
  logic [NUM_IRQ-1:0]             irq_en_q;
  logic [SYS_N-1:0][PRIO_W-1:0]   sys_prio_q;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] irq_prio_q;
  logic                           tick_ie_q;

  wire sel_set  = we_i && (addr_i == A_EN_SET);
  wire sel_clr  = we_i && (addr_i == A_EN_CLR);
  wire sel_spri = we_i && (addr_i == A_SYS_PRI);
  wire sel_ipri = we_i && (addr_i == A_IRQ_PRI);
  wire sel_ctrl = we_i && (addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_en_q   <= '0;
      irq_en_q   <= '0;
      sys_prio_q <= '0;
      irq_prio_q <= '0;
      tick_ie_q  <= 1'b0;
    end else begin
      if (sel_set) begin
        sys_en_q <= sys_en_q | wdata_i[SYS_N-1:0];
        irq_en_q <= irq_en_q | wdata_i[IRQ_EN_LSB +: NUM_IRQ];
      end
      if (sel_clr) begin
        sys_en_q <= sys_en_q & ~wdata_i[SYS_N-1:0];
        irq_en_q <= irq_en_q & ~wdata_i[IRQ_EN_LSB +: NUM_IRQ];
      end
      if (sel_spri)
        for (int k = 0; k < SYS_N; k++) sys_prio_q[k] <= wdata_i[PRIO_W*k +: PRIO_W];
      if (sel_ipri)
        for (int k = 0; k < NUM_IRQ; k++) irq_prio_q[k] <= wdata_i[IRQ_STRIDE*k +: PRIO_W];
      if (sel_ctrl) tick_ie_q <= wdata_i[2];
    end
  end

  assign sys_en_o     = sys_en_q;
  assign irq_en_o     = irq_en_q;
  assign sys_prio_o   = sys_prio_q;
  assign irq_prio_o   = irq_prio_q;
  assign tick_ie_o    = tick_ie_q;
  assign psv_set_o    = sel_ctrl && wdata_i[0];
  assign stk_sw_set_o = sel_ctrl && wdata_i[1];

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  // R4: cleared enables are low after the write
  a_r4_en_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_clr |=> ((sys_en_q & $past(wdata_i[SYS_N-1:0])) == '0));
endmodule

// File: rtl/exc_pend.sv
module exc_pend #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;  // set beats clear
  end

  assign pend_o = pend_q;

  a_r10_set_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/exc_select.sv
module exc_select
  import exc_prio_pkg::*;
#(
  parameter int N      = 18,
  parameter int RANK_W = 4,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N-1:0]                req_i,
  input  logic [N-1:0]                en_i,
  input  logic [N-1:0][RANK_W-1:0]    rank_i,
  output logic                        win_vld_o,
  output logic [IDX_W-1:0]            win_idx_o,
  output logic [RANK_W-1:0]           win_rank_o
);
  // sources ordered by exception number, so strict less keeps the lower number on ties
  always_comb begin
    win_vld_o  = 1'b0;
    win_idx_o  = '0;
    win_rank_o = '1;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && en_i[i] && (!win_vld_o || (rank_i[i] < win_rank_o))) begin
        win_vld_o  = 1'b1;
        win_idx_o  = IDX_W'(i);
        win_rank_o = rank_i[i];
      end
    end
  end

  a_r2_fixed_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i[FIX_N-1:0]) |-> (win_vld_o && (win_idx_o < IDX_W'(FIX_N))));

  a_r4_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_o |-> (req_i[win_idx_o] && en_i[win_idx_o]));

  a_r5_dbg_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_vld_o && (win_idx_o == IDX_W'(FIX_N + DBG_SYS))) |-> en_i[FIX_N + DBG_SYS]);
endmodule

// File: rtl/exc_prio_resolver.sv
module exc_prio_resolver
  import exc_prio_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rst_req_i,
  input  logic                     nmi_i,
  input  logic                     hard_fault_i,
  input  logic                     mem_fault_i,
  input  logic                     bus_fault_i,
  input  logic                     usage_fault_i,
  input  logic                     svc_i,
  input  logic                     dbg_mon_i,
  input  logic                     tick_zero_i,
  input  logic [NUM_IRQ-1:0]       irq_i,
  input  logic                     reg_we_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  input  logic                     act_vld_i,
  input  logic signed [PRIO_W:0]   act_prio_i,
  input  logic                     take_i,
  output logic                     pend_any_o,
  output logic                     preempt_o,
  output logic [NUM_W-1:0]         exc_num_o,
  output logic [OFF_W-1:0]         vec_off_o
);
  localparam int N      = LAT_N + NUM_IRQ;
  localparam int RANK_W = PRIO_W + 1;
  localparam int IDX_W  = $clog2(N);

  logic [SYS_N-1:0]               sys_en;
  logic [NUM_IRQ-1:0]             irq_en;
  logic [SYS_N-1:0][PRIO_W-1:0]   sys_prio;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] irq_prio;
  logic                           psv_set, stk_sw_set, tick_ie;
  logic [NUM_IRQ-1:0]             irq_sync;
  logic [LAT_N-1:0]               set_vec, clr_vec, pend;
  logic [N-1:0]                   req, en;
  logic [N-1:0][RANK_W-1:0]       rank;
  logic                           win_vld;
  logic [IDX_W-1:0]               win_idx, win_idx_q;
  logic [RANK_W-1:0]              win_rank, act_rank;
  exc_num_t                       win_num;

  exc_cfg_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .sys_en_o(sys_en), .irq_en_o(irq_en), .sys_prio_o(sys_prio), .irq_prio_o(irq_prio),
    .psv_set_o(psv_set), .stk_sw_set_o(stk_sw_set), .tick_ie_o(tick_ie)
  );

  exc_irq_sync #(.W(NUM_IRQ)) u_sync (
    .clk_i, .rst_ni, .async_i(irq_i), .sync_o(irq_sync)
  );

  assign set_vec = {(tick_zero_i && tick_ie) || stk_sw_set, psv_set, dbg_mon_i, svc_i,
                    usage_fault_i, bus_fault_i, mem_fault_i, hard_fault_i, nmi_i, rst_req_i};

  wire take_fire = take_i && preempt_o;
  always_comb begin
    for (int k = 0; k < LAT_N; k++) clr_vec[k] = take_fire && (win_idx_q == IDX_W'(k));
  end

  exc_pend #(.N(LAT_N)) u_pend (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_i(clr_vec), .pend_o(pend)
  );

  assign req = {irq_sync, pend};
  assign en  = {irq_en, sys_en, {FIX_N{1'b1}}};

  for (genvar g = 0; g < N; g++) begin : g_rank
    if (g < FIX_N) begin : g_fix
      assign rank[g] = RANK_W'(g);
    end else if (g < LAT_N) begin : g_sys
      assign rank[g] = RANK_W'(sys_prio[g-FIX_N]) + RANK_W'(FIX_N);
    end else begin : g_irq
      assign rank[g] = RANK_W'(irq_prio[g-LAT_N]) + RANK_W'(FIX_N);
    end
  end

  exc_select #(.N(N), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_sel (
    .clk_i, .rst_ni, .req_i(req), .en_i(en), .rank_i(rank),
    .win_vld_o(win_vld), .win_idx_o(win_idx), .win_rank_o(win_rank)
  );

  // signed active level -> rank; idle ranks below every programmable level
  assign act_rank = act_vld_i ? (RANK_W'($unsigned(act_prio_i)) + RANK_W'(FIX_N)) : '1;
  assign win_num  = win_vld ? src_num(int'(win_idx)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_any_o <= 1'b0;
      preempt_o  <= 1'b0;
      exc_num_o  <= '0;
      vec_off_o  <= '0;
      win_idx_q  <= '0;
    end else begin
      pend_any_o <= win_vld;
      preempt_o  <= win_vld && (win_rank < act_rank);
      exc_num_o  <= win_num;
      vec_off_o  <= {win_num, 2'b00};
      win_idx_q  <= win_idx;
    end
  end

  a_r7_pre_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preempt_o |-> pend_any_o);

  a_r12_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_any_o |-> !is_reserved(exc_num_o));

  a_r11_take_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_fire && (win_idx_q < IDX_W'(LAT_N)) && !set_vec[win_idx_q]) |=> !pend[$past(win_idx_q)]);
endmodule

// File: tb/exc_prio_resolver_bench.sv
`timescale 1ns/1ps
module exc_prio_resolver_bench;
  localparam int NI = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rst_req = 0, nmi = 0, hf = 0, mf = 0, bf = 0, uf = 0, svc = 0, dbg = 0, tz = 0;
  logic [NI-1:0] irq = '0;
  logic we = 0; logic [2:0] addr = '0; logic [31:0] wdata = '0;
  logic av = 0; logic signed [3:0] ap = '0; logic take = 0;
  logic pend_any, preempt; logic [7:0] num; logic [9:0] off;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_prio_resolver #(.NUM_IRQ(NI)) u_exc_prio_resolver (
    .clk_i(clk), .rst_ni, .rst_req_i(rst_req), .nmi_i(nmi), .hard_fault_i(hf),
    .mem_fault_i(mf), .bus_fault_i(bf), .usage_fault_i(uf), .svc_i(svc), .dbg_mon_i(dbg),
    .tick_zero_i(tz), .irq_i(irq), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .act_vld_i(av), .act_prio_i(ap), .take_i(take),
    .pend_any_o(pend_any), .preempt_o(preempt), .exc_num_o(num), .vec_off_o(off)
  );

  typedef struct packed {
    logic [7:0] irq; logic av; logic [3:0] ap; logic any; logic [7:0] num; logic pre;
  } vec_t;

  // irq prios: 0:5 1:3 2:3 3:6 4:1 5:7 6:2 7:2
  localparam vec_t TBL [13] = '{
    '{8'h00, 1'b0, 4'd0,  1'b0, 8'd0,  1'b0},
    '{8'h01, 1'b0, 4'd0,  1'b1, 8'd16, 1'b1},
    '{8'h03, 1'b0, 4'd0,  1'b1, 8'd17, 1'b1},
    '{8'h06, 1'b0, 4'd0,  1'b1, 8'd17, 1'b1},
    '{8'h04, 1'b0, 4'd0,  1'b1, 8'd18, 1'b1},
    '{8'hFF, 1'b0, 4'd0,  1'b1, 8'd20, 1'b1},
    '{8'hC0, 1'b0, 4'd0,  1'b1, 8'd22, 1'b1},
    '{8'h10, 1'b1, 4'd1,  1'b1, 8'd20, 1'b0},
    '{8'h10, 1'b1, 4'd2,  1'b1, 8'd20, 1'b1},
    '{8'h20, 1'b1, 4'd7,  1'b1, 8'd21, 1'b0},
    '{8'h20, 1'b1, 4'hF,  1'b1, 8'd21, 1'b0},
    '{8'h08, 1'b1, 4'd7,  1'b1, 8'd19, 1'b1},
    '{8'h00, 1'b1, 4'd7,  1'b0, 8'd0,  1'b0}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic e_any, logic [7:0] e_num, logic e_pre);
    logic [9:0] e_off;
    e_off = {e_num, 2'b00};
    checks++;
    if (pend_any !== e_any || num !== e_num || preempt !== e_pre || off !== e_off) begin
      fails++;
      $display("FAIL %s: any=%0b num=%0d pre=%0b off=0x%0h expected any=%0b num=%0d pre=%0b off=0x%0h",
               req, pend_any, num, preempt, off, e_any, e_num, e_pre, e_off);
    end
    if (pend_any === 1'b1 && (num == 0 || (num >= 7 && num <= 10) || num == 13)) begin
      fails++;
      $display("FAIL R12: reserved number %0d shown, expected a legal one", num);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    we = 1; addr = a; wdata = d; tick(1); we = 0; tick(1);
  endtask

  task automatic do_take();
    take = 1; tick(1); take = 0; tick(1);
  endtask

  function automatic logic [31:0] sys_pri_word();
    int p [7] = '{4, 4, 6, 2, 1, 7, 3};
    logic [31:0] w = '0;
    for (int j = 0; j < 7; j++) w |= 32'(p[j]) << (3 * j);
    return w;
  endfunction

  function automatic logic [31:0] irq_pri_word();
    int p [8] = '{5, 3, 3, 6, 1, 7, 2, 2};
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) w |= 32'(p[k]) << (4 * k);
    return w;
  endfunction

  initial begin
    #1;
    tick(2);
    chk("R1 in reset", 0, 0, 0);
    rst_ni = 1;
    tick(1);
    chk("R1 after release", 0, 0, 0);

    wr(0, 32'h0000_FF7F);
    wr(2, sys_pri_word());
    wr(3, irq_pri_word());

    // R3 R7 R9 table
    for (int i = 0; i < 13; i++) begin
      irq = TBL[i].irq; av = TBL[i].av; ap = TBL[i].ap;
      tick(3);
      chk($sformatf("R3/R7/R9 vector %0d", i), TBL[i].any, TBL[i].num, TBL[i].pre);
    end
    av = 0; ap = 0;
    tick(1);

    // R9 latency
    irq = 8'h01; tick(2);
    chk("R9 not before third edge", 0, 0, 0);
    tick(1);
    chk("R9 at third edge", 1, 16, 1);
    irq = 0; tick(3);

    // R10 latency, R6 NMI offset
    nmi = 1; tick(1);
    chk("R10 not before second edge", 0, 0, 0);
    nmi = 0; tick(1);
    chk("R10 R6 nmi", 1, 2, 1);

    // R2 reset request over NMI, R11 take
    rst_req = 1; tick(1); rst_req = 0; tick(1);
    chk("R2 reset beats nmi", 1, 1, 1);
    do_take();
    chk("R11 take clears reset", 1, 2, 1);
    do_take();
    chk("R11 take clears nmi", 0, 0, 0);

    // R2 hard fault over svc; R6 svc offset
    hf = 1; svc = 1; tick(1); hf = 0; svc = 0; tick(1);
    chk("R2 hard fault beats svc", 1, 3, 1);
    do_take();
    chk("R6 svc offset 0x2C", 1, 11, 1);
    do_take();

    // R3 tie among system faults
    mf = 1; bf = 1; tick(1); mf = 0; bf = 0; tick(1);
    chk("R3 tie mem over bus", 1, 4, 1);
    do_take();
    chk("R3 bus next", 1, 5, 1);
    do_take();
    chk("R3 cleared", 0, 0, 0);

    // R3 lower value beats lower number: irq4 prio1 vs svc prio2
    irq = 8'h10; tick(3);
    svc = 1; tick(1); svc = 0; tick(1);
    chk("R3 irq4 over svc", 1, 20, 1);
    irq = 0; tick(3);
    chk("R3 svc after irq drops", 1, 11, 1);

    // R11 take ignored without preempt; R7 idle preempts
    av = 1; ap = 4'sd0; tick(1);
    chk("R7 svc below active 0", 1, 11, 0);
    do_take();
    chk("R11 take without preempt ignored", 1, 11, 0);
    av = 0; tick(1);
    chk("R7 idle preempts", 1, 11, 1);
    do_take();
    chk("R11 svc cleared", 0, 0, 0);

    // R4 disabled stays pending, R13 write latency
    wr(1, 32'h0000_0008);
    svc = 1; tick(1); svc = 0; tick(1);
    chk("R4 disabled svc hidden", 0, 0, 0);
    we = 1; addr = 0; wdata = 32'h8; tick(1); we = 0;
    chk("R13 not before second edge", 0, 0, 0);
    tick(1);
    chk("R4 R13 enabled svc shown", 1, 11, 1);
    do_take();

    // R5 debug monitor gate
    wr(1, 32'h0000_0010);
    dbg = 1; tick(1); dbg = 0; tick(1);
    chk("R5 dbg disabled", 0, 0, 0);
    wr(0, 32'h0000_0010);
    chk("R5 R6 dbg offset 0x30", 1, 12, 1);
    do_take();

    // R8 pendable service and tick
    wr(4, 32'h1);
    chk("R8 pendsv by write", 1, 14, 1);
    do_take();
    tz = 1; tick(1); tz = 0; tick(1);
    chk("R8 tick ignored while ie clear", 0, 0, 0);
    wr(4, 32'h4);
    tz = 1; tick(1); tz = 0; tick(1);
    chk("R8 tick with ie", 1, 15, 1);
    do_take();
    wr(4, 32'h2);
    chk("R8 systick by write", 1, 15, 1);
    do_take();
    chk("R8 cleared", 0, 0, 0);

    // R7 fixed active levels
    av = 1; ap = -4'sd2;
    hf = 1; tick(1); hf = 0; tick(1);
    chk("R7 hard fault under active nmi", 1, 3, 0);
    ap = -4'sd3; tick(1);
    chk("R7 reset level active", 1, 3, 0);
    av = 0; tick(1);
    chk("R7 idle lets hard fault preempt", 1, 3, 1);
    do_take();
    chk("R11 hard fault cleared", 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    done = 1;
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule